// File: doc/BRIEF.md
# Four-channel buffered PWM controller

This block generates four independent pulse-width modulated outputs. It is configured through a small memory-mapped register port. Each channel has the following settings:

- a power-of-two clock prescaler;
- an output polarity;
- a 16-bit period and a 16-bit duty value.

A channel counts prescaled ticks from zero up to one less than its period. It drives its output active while the count is below the duty value. Channels are switched on and off through two global bitmask registers: one write-one-to-set, one write-one-to-clear. A status register shows which channels are running.

Duty and period may be written directly only while a channel is stopped. While it runs, new values go to shadow update registers. The block copies them into the working registers on the clock edge where the counter returns to zero, so no shortened or stretched pulse is ever produced.

The register port is a valid/ready command channel with a registered read response:

- A command (read or write) is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both high.
- Every accepted read produces exactly one response, in order, on `rsp_valid`/`rsp_data`.
- The response is held until `rsp_ready` is high.
- While a response waits, `cmd_ready` is low, so at most one read is in flight.
- Writes produce no response.

Top module: `quad_pwm`

## Requirements
- R1: A read accepted on edge E shows `rsp_valid` high with its data after E. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged and `cmd_ready` is low.
- R2: Writing offset 0x04 sets channel n running for every 1 in bit n (n = 0..3). Zero bits leave that channel unchanged.
- R3: Writing offset 0x08 stops channel n for every 1 in bit n. Zero bits leave that channel unchanged.
- R4: Reading offset 0x0C returns the running-channel mask in bits 3:0, with bit n for channel n, and zeros above.
- R5: Channel n owns the window at 0x200 + n*0x20, laid out as follows. Duty and period keep only the low 16 bits of a write; the upper bits read as zero.

  | Offset | Register |
  |---|---|
  | +0x00 | mode |
  | +0x04 | duty |
  | +0x08 | duty update |
  | +0x0C | period |
  | +0x10 | period update |
- R6: In the mode register, bits 3:0 are the prescale exponent p, and a written value above 10 is stored as 10. Bit 9 is polarity: 0 is normal, 1 is inverted. All other bits read as zero.
- R7: A running channel advances its count once every 2^p clocks and wraps from period-1 to 0. A period of 0 keeps the count at 0.
- R8: With normal polarity the output is 1 while count < duty, else 0. So duty 0 gives a constant 0, and duty >= period gives a constant 1. Inverted polarity gives the complement.
- R9: A stopped channel holds count and prescaler at zero and drives its output to the polarity bit. After enabling, the first count step occurs 2^p clocks after the enabling edge.
- R10: While a channel runs, direct writes to its duty and period registers are ignored.
- R11: An update register write is held in a shadow, and the update offset reads back the shadow value. While the channel runs, the shadow is copied to duty or period on the edge where the count wraps to 0. While it is stopped, the copy takes effect at once.
- R12: Reads of unmapped offsets return 0, and writes to them change nothing. The enable and disable offsets also read 0. Reset clears all registers, stops all channels and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 12 | Byte offset |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Read data |
| pwm_out | output | 4 | One output per channel, bit n for channel n |

## Verification
The assertions check the following on every cycle:

- the response holds under back-pressure;
- the enable mask changes only through accepted writes, in the set or clear sense of the offset;
- a stopped channel keeps its counter and prescaler at zero;
- the count stays below a nonzero period;
- working duty and period change on a running channel only at a wrap;
- direct writes while running leave the working values alone;
- the prescale exponent never exceeds its cap.

Only the bench scenarios show the following:

- the exact waveform phase after enabling;
- the duty extremes;
- the clamp to the 1024-clock tick;
- shadow values appearing one full period later;
- unmapped offsets reading back zero.

// File: rtl/quad_pwm_pkg.sv
package quad_pwm_pkg;

  // Global register offsets
  localparam int OFS_SET_MASK = 'h04;
  localparam int OFS_CLR_MASK = 'h08;
  localparam int OFS_RUN_STAT = 'h0C;

  // Mode register bit positions
  localparam int POL_BIT = 9;

  // Which register of a channel window a command targets
  typedef enum logic [2:0] {
    SLOT_MODE      = 3'd0,
    SLOT_DUTY      = 3'd1,
    SLOT_DUTY_NEXT = 3'd2,
    SLOT_PER       = 3'd3,
    SLOT_PER_NEXT  = 3'd4,
    SLOT_NONE      = 3'd7
  } slot_e;

  function automatic slot_e slot_of(input logic [4:0] ofs);
    case (ofs)
      5'h00:   return SLOT_MODE;
      5'h04:   return SLOT_DUTY;
      5'h08:   return SLOT_DUTY_NEXT;
      5'h0C:   return SLOT_PER;
      5'h10:   return SLOT_PER_NEXT;
      default: return SLOT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/qp_divider.sv
module qp_divider #(
  parameter int PRES_W   = 4,
  parameter int PRES_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PRES_W-1:0] pres,
  output logic              tick
);
  localparam int PCW = PRES_MAX + 1;

  logic [PCW-1:0] pc;
  logic [PCW-1:0] mask;

  assign mask = (PCW'(1) << pres) - PCW'(1);
  assign tick = run && (pc >= mask);

  always_ff @(posedge clk) begin
    if (!rst_n)    pc <= '0;
    else if (!run) pc <= '0;
    else if (tick) pc <= '0;
    else           pc <= pc + PCW'(1);
  end

  // R9: a stopped channel keeps its prescaler cleared
  assert_div_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pc == '0));

endmodule

// File: rtl/qp_channel.sv
module qp_channel
  import quad_pwm_pkg::*;
#(
  parameter int CW       = 16,
  parameter int PRES_W   = 4,
  parameter int PRES_MAX = 10,
  parameter int DW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr,
  input  slot_e         slot,
  input  logic [CW-1:0] wdata,
  output logic [DW-1:0] rd_word,
  output logic          pwm_o
);

  logic [PRES_W-1:0] pres_q;
  logic              pol_q;
  logic [CW-1:0]     duty_q, per_q, duty_sh, per_sh;
  logic              duty_pend, per_pend;
  logic [CW-1:0]     cnt;
  logic              tick, last, wrap;

  qp_divider #(.PRES_W(PRES_W), .PRES_MAX(PRES_MAX)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (en),
    .pres (pres_q),
    .tick (tick)
  );

  assign last = ({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, per_q};
  assign wrap = tick && last;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= last ? '0 : cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres_q    <= '0;
      pol_q     <= 1'b0;
      duty_q    <= '0;
      per_q     <= '0;
      duty_sh   <= '0;
      per_sh    <= '0;
      duty_pend <= 1'b0;
      per_pend  <= 1'b0;
    end else begin
      // commit shadows at a wrap, or at once while stopped
      if (wrap || !en) begin
        if (duty_pend) begin
          duty_q    <= duty_sh;
          duty_pend <= 1'b0;
        end
        if (per_pend) begin
          per_q    <= per_sh;
          per_pend <= 1'b0;
        end
      end
      if (wr) begin
        case (slot)
          SLOT_MODE: begin
            pres_q <= (int'(wdata[PRES_W-1:0]) > PRES_MAX) ? PRES_W'(PRES_MAX)
                                                            : wdata[PRES_W-1:0];
            pol_q  <= wdata[POL_BIT];
          end
          SLOT_DUTY: if (!en) duty_q <= wdata;
          SLOT_PER:  if (!en) per_q  <= wdata;
          SLOT_DUTY_NEXT: begin
            duty_sh <= wdata;
            if (en) duty_pend <= 1'b1;
            else begin
              duty_q    <= wdata;
              duty_pend <= 1'b0;
            end
          end
          SLOT_PER_NEXT: begin
            per_sh <= wdata;
            if (en) per_pend <= 1'b1;
            else begin
              per_q    <= wdata;
              per_pend <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pwm_o = en ? ((cnt < duty_q) ^ pol_q) : pol_q;

  always_comb begin
    rd_word = '0;
    case (slot)
      SLOT_MODE: begin
        rd_word[PRES_W-1:0] = pres_q;
        rd_word[POL_BIT]    = pol_q;
      end
      SLOT_DUTY:      rd_word[CW-1:0] = duty_q;
      SLOT_DUTY_NEXT: rd_word[CW-1:0] = duty_sh;
      SLOT_PER:       rd_word[CW-1:0] = per_q;
      SLOT_PER_NEXT:  rd_word[CW-1:0] = per_sh;
      default:        rd_word = '0;
    endcase
  end

  assert_idle_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

  assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per_q != '0) |-> (cnt < per_q));

  assert_duty_at_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(duty_q)) |-> $past(wrap));

  assert_per_at_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(per_q)) |-> $past(wrap));

  assert_direct_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && en && slot == SLOT_DUTY && !wrap) |=> $stable(duty_q));

  assert_pres_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pres_q) <= PRES_MAX);

endmodule

// File: rtl/qp_bus.sv
module qp_bus
  import quad_pwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int CW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic                    cmd_write,
  input  logic [AW-1:0]           cmd_addr,
  input  logic [DW-1:0]           cmd_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DW-1:0]           rsp_data,
  output logic [NCH-1:0]          ch_en,
  output logic [NCH-1:0]          ch_wr,
  output slot_e                   ch_slot,
  output logic [CW-1:0]           ch_wdata,
  input  logic [NCH-1:0][DW-1:0]  ch_rd
);
  localparam int HIW = AW - 9;

  logic          acc;
  logic [HIW-1:0] hi;
  logic [3:0]    idx;
  logic          in_win, ch_hit;
  logic [DW-1:0] rdv;
  logic          unused_bits;

  assign cmd_ready   = !rsp_valid || rsp_ready;
  assign acc         = cmd_valid && cmd_ready;
  assign hi          = cmd_addr[AW-1:9];
  assign idx         = cmd_addr[8:5];
  assign in_win      = (hi == HIW'(1));
  assign ch_hit      = in_win && (int'(idx) < NCH);
  assign ch_slot     = ch_hit ? slot_of(cmd_addr[4:0]) : SLOT_NONE;
  assign ch_wdata    = cmd_wdata[CW-1:0];
  assign unused_bits = ^cmd_wdata[DW-1:CW];

  for (genvar g = 0; g < NCH; g++) begin : g_wr
    assign ch_wr[g] = acc && cmd_write && ch_hit && (int'(idx) == g)
                      && (ch_slot != SLOT_NONE);
  end

  always_comb begin
    rdv = '0;
    if (cmd_addr == AW'(OFS_RUN_STAT)) rdv[NCH-1:0] = ch_en;
    else if (ch_hit) begin
      for (int i = 0; i < NCH; i++)
        if (int'(idx) == i) rdv = ch_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ch_en <= '0;
    else if (acc && cmd_write) begin
      if (cmd_addr == AW'(OFS_SET_MASK))      ch_en <= ch_en | cmd_wdata[NCH-1:0];
      else if (cmd_addr == AW'(OFS_CLR_MASK)) ch_en <= ch_en & ~cmd_wdata[NCH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc && !cmd_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rdv;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_mask_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && cmd_write) |=> $stable(ch_en));

  assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_write && cmd_addr == AW'(OFS_SET_MASK))
      |=> ((ch_en & $past(cmd_wdata[NCH-1:0])) == $past(cmd_wdata[NCH-1:0])));

  assert_mask_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_write && cmd_addr == AW'(OFS_CLR_MASK))
      |=> ((ch_en & $past(cmd_wdata[NCH-1:0])) == '0));

endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
  import quad_pwm_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int CW       = 16,
  parameter int PRES_W   = 4,
  parameter int PRES_MAX = 10,
  parameter int AW       = 12,
  parameter int DW       = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic           cmd_write,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [DW-1:0]  cmd_wdata,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [DW-1:0]  rsp_data,
  output logic [NCH-1:0] pwm_out
);

  logic [NCH-1:0]         ch_en;
  logic [NCH-1:0]         ch_wr;
  slot_e                  ch_slot;
  logic [CW-1:0]          ch_wdata;
  logic [NCH-1:0][DW-1:0] ch_rd;

  qp_bus #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_write(cmd_write),
    .cmd_addr (cmd_addr),
    .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data),
    .ch_en    (ch_en),
    .ch_wr    (ch_wr),
    .ch_slot  (ch_slot),
    .ch_wdata (ch_wdata),
    .ch_rd    (ch_rd)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    qp_channel #(.CW(CW), .PRES_W(PRES_W), .PRES_MAX(PRES_MAX), .DW(DW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ch_en[g]),
      .wr     (ch_wr[g]),
      .slot   (ch_slot),
      .wdata  (ch_wdata),
      .rd_word(ch_rd[g]),
      .pwm_o  (pwm_out[g])
    );
  end

endmodule

// File: tb/quad_pwm_test.sv
module quad_pwm_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, rsp_ready = 1'b1;
  logic [11:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic [3:0]  pwm_out;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] expq[$];
  string       tagq[$];

  // reference state, derived from the requirements
  bit m_en[NCH];
  int m_pres[NCH], m_pol[NCH], m_duty[NCH], m_per[NCH];
  int m_dsh[NCH], m_psh[NCH], m_dp[NCH], m_pp[NCH], m_pc[NCH], m_cnt[NCH];

  quad_pwm uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Model step: counters use the state before the edge, then writes apply
  always @(posedge clk) begin : model
    bit acc, tk, lst, wrp;
    int a, ci, off;
    logic [31:0] w;
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_en[i] = 0; m_pres[i] = 0; m_pol[i] = 0; m_duty[i] = 0; m_per[i] = 0;
        m_dsh[i] = 0; m_psh[i] = 0; m_dp[i] = 0; m_pp[i] = 0; m_pc[i] = 0; m_cnt[i] = 0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        tk  = m_en[i] && (m_pc[i] >= (1 << m_pres[i]) - 1);
        lst = (m_cnt[i] + 1) >= m_per[i];
        wrp = tk && lst;
        if (!m_en[i] || tk) m_pc[i] = 0; else m_pc[i] = m_pc[i] + 1;
        if (!m_en[i]) m_cnt[i] = 0;
        else if (tk) m_cnt[i] = lst ? 0 : m_cnt[i] + 1;
        if (wrp || !m_en[i]) begin
          if (m_dp[i] != 0) begin m_duty[i] = m_dsh[i]; m_dp[i] = 0; end
          if (m_pp[i] != 0) begin m_per[i] = m_psh[i]; m_pp[i] = 0; end
        end
      end
      acc = cmd_valid && cmd_ready;
      a = int'(cmd_addr);
      w = cmd_wdata;
      if (acc && cmd_write) begin
        if (a == 'h04) begin
          for (int i = 0; i < NCH; i++) if (w[i]) m_en[i] = 1;
        end else if (a == 'h08) begin
          for (int i = 0; i < NCH; i++) if (w[i]) m_en[i] = 0;
        end else if (a >= 'h200 && a < 'h200 + NCH * 'h20) begin
          ci  = (a - 'h200) / 'h20;
          off = a % 'h20;
          case (off)
            'h00: begin m_pres[ci] = (w[3:0] > 10) ? 10 : int'(w[3:0]); m_pol[ci] = int'(w[9]); end
            'h04: if (!m_en[ci]) m_duty[ci] = int'(w[15:0]);
            'h0C: if (!m_en[ci]) m_per[ci] = int'(w[15:0]);
            'h08: begin m_dsh[ci] = int'(w[15:0]);
                    if (m_en[ci]) m_dp[ci] = 1; else begin m_duty[ci] = m_dsh[ci]; m_dp[ci] = 0; end end
            'h10: begin m_psh[ci] = int'(w[15:0]);
                    if (m_en[ci]) m_pp[ci] = 1; else begin m_per[ci] = m_psh[ci]; m_pp[ci] = 0; end end
            default: ;
          endcase
        end
      end
    end
  end

  // Monitor: waveform against the model every cycle (R7/R8/R9)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        logic e;
        e = m_en[i] ? ((m_cnt[i] < m_duty[i]) ^ (m_pol[i] != 0)) : (m_pol[i] != 0);
        chk(pwm_out[i] == e, $sformatf("R8 wave ch%0d", i), 32'(pwm_out[i]), 32'(e));
      end
    end
  end

  // Monitor: read responses against the scoreboard queue
  always @(posedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (expq.size() == 0) chk(0, "R1 unexpected response", rsp_data, 32'hx);
      else begin
        logic [31:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    expq.push_back(e); tagq.push_back(t);
    cmd_valid = 1; cmd_write = 0; cmd_addr = a; cmd_wdata = '0;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] held;
    idle(5);
    rst_n = 1;
    @(negedge clk);
    chk(pwm_out == 4'b0, "R12 reset outputs", 32'(pwm_out), 0);
    rd('h00C, 0, "R12 reset status");

    // R5: field widths and window map
    wr('h204, 32'hFFFF_0002); rd('h204, 2, "R5 duty width");
    wr('h20C, 32'h1234_0004); rd('h20C, 4, "R5 period width");
    wr('h204, 1);
    // R6: mode fields and clamp
    wr('h220, 32'hFFFF_FFFF); rd('h220, 32'h20A, "R6 mode fields");
    wr('h220, 32'h200); wr('h22C, 5); wr('h224, 2);
    rd('h00C, 0, "R9 still stopped");

    // R2/R4: start ch0, ch1
    wr('h004, 3); idle(20);
    rd('h00C, 3, "R4 status");
    wr('h004, 0); rd('h00C, 3, "R2 zero bits");
    rd('h004, 0, "R12 enable reads zero");
    // R10: direct writes while running
    wr('h204, 3); rd('h204, 1, "R10 duty kept");
    wr('h20C, 9); rd('h20C, 4, "R10 period kept");

    // R11: shadows commit at wrap (pres 3, period 10: 80 clocks)
    wr('h240, 3); wr('h24C, 10); wr('h244, 4); wr('h004, 4);
    wr('h248, 7); rd('h248, 7, "R11 shadow readback");
    rd('h244, 4, "R11 duty before wrap");
    wr('h250, 6); rd('h24C, 10, "R11 period before wrap");
    idle(100);
    rd('h244, 7, "R11 duty after wrap");
    rd('h24C, 6, "R11 period after wrap");
    rd('h00C, 7, "R4 status three");

    // R3: stop ch1
    wr('h008, 2); rd('h00C, 5, "R3 clear");
    wr('h008, 0); rd('h00C, 5, "R3 zero bits");

    // R8 extremes on ch3
    wr('h260, 1); wr('h26C, 3); wr('h264, 0); wr('h004, 8); idle(20);
    rd('h00C, 32'hD, "R4 status");
    wr('h008, 8); wr('h264, 7); wr('h004, 8); idle(20);
    wr('h008, 8); wr('h268, 2);
    rd('h264, 2, "R11 stopped applies at once");
    rd('h268, 2, "R11 stopped shadow");

    // R6/R7: prescale clamped to 10 -> 1024 clocks per step
    wr('h260, 32'hF); rd('h260, 32'hA, "R6 clamp");
    wr('h26C, 2); wr('h264, 1); wr('h004, 8); idle(2200);

    // R12: unmapped offsets
    wr('h100, 32'hFFFF_FFFF); rd('h100, 0, "R12 unmapped read");
    rd('h280, 0, "R12 missing channel");
    wr('h214, 32'hFFFF); rd('h214, 0, "R12 window hole");
    rd('h204, 1, "R12 hole write ignored");
    rd('h20C, 4, "R12 hole write ignored");

    // R1: response back-pressure
    @(negedge clk);
    rsp_ready = 0;
    expq.push_back(32'hD); tagq.push_back("R1 held response");
    cmd_valid = 1; cmd_write = 0; cmd_addr = 'h00C;
    @(negedge clk);
    cmd_valid = 0;
    chk(rsp_valid == 1, "R1 valid", 32'(rsp_valid), 1);
    chk(cmd_ready == 0, "R1 ready low", 32'(cmd_ready), 0);
    held = rsp_data;
    idle(3);
    chk(rsp_valid == 1 && rsp_data == held, "R1 stable", rsp_data, held);
    rsp_ready = 1;
    idle(4);
    chk(rsp_valid == 0, "R1 drained", 32'(rsp_valid), 0);
    chk(expq.size() == 0, "R1 all responses", 32'(expq.size()), 0);
    summary();
  end
endmodule